// File: doc/BRIEF.md
# Cascadable Up/Down Counter Slice

This block is a synchronous counter slice of parameterised width (four bits by default). It counts up or down and can be built in one of two variants chosen by a parameter: decade, which cycles through 0 to 9, or binary, which cycles through 0 to 2^W-1. The counter can be cleared at once by an asynchronous input or cleared on the next clock edge. It can be loaded with a parallel word, or stepped when both of its active-low enables are asserted. The count drives an output bus that an active-low output enable can release to high impedance. Releasing the bus does not stop the counter.

Two carry outputs mark the terminal count: a ripple carry and a clocked carry. Slices are chained by feeding either carry into the next slice's T enable. The ripple carry depends only on the count, the direction and T. The clocked carry is further gated by the P enable and by the low phase of the clock, so it cannot glitch while the count registers settle after a rising edge. When the asynchronous clear is released, the internal reset is deasserted synchronously, through two flops, before counting resumes.

Top module: `updn_count_slice`

## Requirements
- R1: While clr_n is low, cnt is 0 within the same time step as the falling edge of clr_n, whatever the other inputs are.
- R2: After clr_n rises, cnt stays 0 through the next two rising clock edges. The third rising edge is the first one at which the count can change.
- R3: When sclr_n is low at a rising edge, cnt becomes 0. This takes priority over load and count.
- R4: When sclr_n is high and ld_n is low at a rising edge, cnt takes the value of din, with din[0] as the least significant bit. Load takes priority over count.
- R5: With sclr_n and ld_n high, cnt changes only at a rising edge where both enp_n and ent_n are low. Otherwise it holds.
- R6: When counting, the count goes up when up=1 and down when up=0. The decade variant wraps from 9 to 0 going up and from 0 to 9 going down. The binary variant wraps from 15 to 0 going up and from 0 to 15 going down.
- R7: In the decade variant, a count above 9 (reached by a load of 10 to 15) goes to 0 on the next up step and to its own value minus one on the next down step.
- R8: rco_n is low exactly when ent_n is low and cnt is at its terminal value. The terminal value is the maximum (9 or 15) when up=1 and 0 when up=0.
- R9: cco_n is low exactly when clk is low, rco_n is low, and enp_n and ent_n are both low. It is always high while clk is high.
- R10: drv_en equals the inverse of oe_n. When drv_en is 1, q carries cnt; when it is 0, q is high impedance. oe_n has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous actions occur on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| sclr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Parallel load, active low |
| enp_n | input | 1 | Count enable P, active low |
| ent_n | input | 1 | Count enable T, active low; also gates the carries |
| up | input | 1 | Direction: 1 up, 0 down |
| din | input | W | Parallel load word, bit 0 least significant |
| oe_n | input | 1 | Output enable, active low |
| q | output | W | Count bus, high impedance when released |
| cnt | output | W | Internal count, always driven |
| drv_en | output | 1 | Internal drive enable for q |
| rco_n | output | 1 | Ripple carry, active low |
| cco_n | output | 1 | Clocked carry, active low, low clock phase only |

## Verification
Random control words use biased probabilities so that clear, load, count in each direction and hold all occur often. This separates the priority order from the enable gating. Directed sequences walk the count across both wrap points in each direction for a decade instance and a binary instance driven in parallel. These distinguish the terminal value used for wrapping, and for the carries, in each variant. Loads of 10 to 15 into the decade instance, followed by one step up or down, tell the recovery rule apart from a plain wrap. An asynchronous clear asserted in mid-cycle, then released, exposes both the immediate zeroing and the two-edge hold after release.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_ZERO = 3'd1,
    OP_LOAD = 3'd2,
    OP_UP   = 3'd3,
    OP_DOWN = 3'd4
  } op_e;
endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[i] <= 1'b0;
          else         sh_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sh_q[i] <= 1'b0;
          else         sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_ok = sh_q[STAGES-1];
endmodule

// File: rtl/updn_ctl.sv
module updn_ctl
  import updn_pkg::*;
(
  input  logic sclr_n,
  input  logic ld_n,
  input  logic enp_n,
  input  logic ent_n,
  input  logic up,
  output op_e  op
);
  always_comb begin
    if (!sclr_n)                 op = OP_ZERO;
    else if (!ld_n)              op = OP_LOAD;
    else if (!enp_n && !ent_n)   op = up ? OP_UP : OP_DOWN;
    else                         op = OP_HOLD;
  end
endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  op_e          op,
  input  logic [W-1:0] din,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP_C = W'(MAXV);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt;
    cnt_en = 1'b1;
    case (op)
      OP_ZERO: cnt_d = '0;
      OP_LOAD: cnt_d = din;
      OP_UP:   cnt_d = (cnt >= TOP_C) ? '0 : cnt + W'(1);
      OP_DOWN: cnt_d = (cnt == '0) ? TOP_C : cnt - W'(1);
      default: cnt_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/updn_carry.sv
module updn_carry #(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input  logic         clk,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic         enp_n,
  input  logic         ent_n,
  output logic         rco_n,
  output logic         cco_n
);
  localparam logic [W-1:0] TOP_C = W'(MAXV);

  logic at_term;

  always_comb begin
    at_term = up ? (cnt == TOP_C) : (cnt == '0);
    rco_n   = ~(at_term & ~ent_n);
    cco_n   = ~(~clk & ~rco_n & ~enp_n & ~ent_n);
  end
endmodule

// File: rtl/updn_count_slice.sv
module updn_count_slice
  import updn_pkg::*;
#(
  parameter bit DECADE      = 1'b1,
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         sclr_n,
  input  logic         ld_n,
  input  logic         enp_n,
  input  logic         ent_n,
  input  logic         up,
  input  logic [W-1:0] din,
  input  logic         oe_n,
  output logic [W-1:0] q,
  output logic [W-1:0] cnt,
  output logic         drv_en,
  output logic         rco_n,
  output logic         cco_n
);
  localparam int MAXV = DECADE ? 9 : (1 << W) - 1;

  logic rst_ok;
  op_e  op;

  updn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(clr_n), .rst_ok(rst_ok)
  );

  updn_ctl u_ctl (
    .sclr_n(sclr_n), .ld_n(ld_n), .enp_n(enp_n), .ent_n(ent_n),
    .up(up), .op(op)
  );

  updn_core #(.W(W), .MAXV(MAXV)) u_core (
    .clk(clk), .rst_n(rst_ok), .op(op), .din(din), .cnt(cnt)
  );

  updn_carry #(.W(W), .MAXV(MAXV)) u_carry (
    .clk(clk), .cnt(cnt), .up(up), .enp_n(enp_n), .ent_n(ent_n),
    .rco_n(rco_n), .cco_n(cco_n)
  );

  assign drv_en = ~oe_n;
  assign q      = drv_en ? cnt : {W{1'bz}};
endmodule

// File: rtl/updn_count_slice_chk.sv
module updn_count_slice_chk #(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input logic         clk,
  input logic         clr_n,
  input logic         rst_ok,
  input logic         sclr_n,
  input logic         ld_n,
  input logic         enp_n,
  input logic         ent_n,
  input logic         up,
  input logic [W-1:0] din,
  input logic [W-1:0] cnt,
  input logic         rco_n,
  input logic         cco_n
);
  localparam logic [W-1:0] TOP_C = W'(MAXV);

  assert_clear_zero_R1: assert property (@(posedge clk)
    disable iff (clr_n) 1'b1 |-> (cnt == '0));

  assert_sync_clear_R3: assert property (@(posedge clk)
    disable iff (!rst_ok) !sclr_n |=> (cnt == '0));

  assert_load_R4: assert property (@(posedge clk)
    disable iff (!rst_ok) (sclr_n && !ld_n) |=> (cnt == $past(din)));

  assert_hold_R5: assert property (@(posedge clk)
    disable iff (!rst_ok) (sclr_n && ld_n && (enp_n || ent_n)) |=> $stable(cnt));

  assert_up_wrap_R6: assert property (@(posedge clk)
    disable iff (!rst_ok)
    (sclr_n && ld_n && !enp_n && !ent_n && up && cnt == TOP_C) |=> (cnt == '0));

  assert_down_wrap_R6: assert property (@(posedge clk)
    disable iff (!rst_ok)
    (sclr_n && ld_n && !enp_n && !ent_n && !up && cnt == '0) |=> (cnt == TOP_C));

  assert_rco_gate_R8: assert property (@(posedge clk)
    disable iff (!clr_n) ent_n |-> rco_n);

  assert_cco_high_phase_R9: assert property (@(negedge clk)
    disable iff (!clr_n) 1'b1 |-> cco_n);
endmodule

bind updn_count_slice updn_count_slice_chk #(.W(W), .MAXV(MAXV)) u_chk (
  .clk(clk), .clr_n(clr_n), .rst_ok(rst_ok), .sclr_n(sclr_n), .ld_n(ld_n),
  .enp_n(enp_n), .ent_n(ent_n), .up(up), .din(din), .cnt(cnt),
  .rco_n(rco_n), .cco_n(cco_n)
);

// File: tb/updn_count_slice_tb.sv
module updn_count_slice_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clr_n, sclr_n, ld_n, enp_n, ent_n, up, oe_n;
  logic [3:0] din;
  logic [3:0] q_d, cnt_d, q_b, cnt_b;
  logic       drv_d, drv_b, rco_d, rco_b, cco_d, cco_b;

  int total = 0, bad = 0, hold = 0;
  bit done = 0;
  logic [3:0] m_d, m_b;

  updn_count_slice #(.DECADE(1'b1)) u_dut (
    .clk(clk), .clr_n(clr_n), .sclr_n(sclr_n), .ld_n(ld_n), .enp_n(enp_n),
    .ent_n(ent_n), .up(up), .din(din), .oe_n(oe_n), .q(q_d), .cnt(cnt_d),
    .drv_en(drv_d), .rco_n(rco_d), .cco_n(cco_d));

  updn_count_slice #(.DECADE(1'b0)) u_dut_bin (
    .clk(clk), .clr_n(clr_n), .sclr_n(sclr_n), .ld_n(ld_n), .enp_n(enp_n),
    .ent_n(ent_n), .up(up), .din(din), .oe_n(oe_n), .q(q_b), .cnt(cnt_b),
    .drv_en(drv_b), .rco_n(rco_b), .cco_n(cco_b));

  function automatic logic [3:0] nxt(input logic [3:0] c, input int mx);
    if (!sclr_n) return 4'd0;
    if (!ld_n) return din;
    if (enp_n || ent_n) return c;
    if (up) return (int'(c) >= mx) ? 4'd0 : c + 4'd1;
    return (c == 4'd0) ? 4'(mx) : c - 4'd1;
  endfunction

  function automatic logic exp_rco(input logic [3:0] c, input int mx);
    return !(!ent_n && (up ? (int'(c) == mx) : (c == 4'd0)));
  endfunction

  function automatic string tag(input logic [3:0] c);
    if (hold > 0) return "R2";
    if (!sclr_n) return "R3";
    if (!ld_n) return "R4";
    if (enp_n || ent_n) return "R5";
    if (c > 4'd9) return "R7";
    return "R6";
  endfunction

  task automatic chk(input string r, input string what, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    string t;
    @(negedge clk); #1;
    chk("R8", "rco dec", {3'b0, rco_d}, {3'b0, exp_rco(m_d, 9)});
    chk("R8", "rco bin", {3'b0, rco_b}, {3'b0, exp_rco(m_b, 15)});
    chk("R9", "cco low dec", {3'b0, cco_d}, {3'b0, !(!exp_rco(m_d, 9) && !enp_n && !ent_n)});
    chk("R9", "cco low bin", {3'b0, cco_b}, {3'b0, !(!exp_rco(m_b, 15) && !enp_n && !ent_n)});
    @(posedge clk);
    t = tag(m_d);
    if (!clr_n) begin m_d = 4'd0; m_b = 4'd0; hold = 2; t = "R1"; end
    else if (hold > 0) begin hold--; m_d = 4'd0; m_b = 4'd0; end
    else begin m_d = nxt(m_d, 9); m_b = nxt(m_b, 15); end
    #1;
    chk(t, "cnt dec", cnt_d, m_d);
    chk(t, "cnt bin", cnt_b, m_b);
    chk("R9", "cco high", {2'b0, cco_d, cco_b}, 4'b0011);
    chk("R10", "drv_en", {2'b0, drv_d, drv_b}, {2'b0, !oe_n, !oe_n});
    if (!oe_n) begin
      chk("R10", "q dec", q_d, m_d);
      chk("R10", "q bin", q_b, m_b);
    end
  endtask

  task automatic setc(input logic s, l, p, tt, u, input logic [3:0] d);
    sclr_n = s; ld_n = l; enp_n = p; ent_n = tt; up = u; din = d;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    clr_n = 1'b0; oe_n = 1'b0;
    setc(1, 1, 1, 1, 1, 4'd0);
    m_d = 0; m_b = 0; hold = 2;
    #3;
    chk("R1", "reset cnt dec", cnt_d, 4'd0);
    chk("R1", "reset cnt bin", cnt_b, 4'd0);
    cyc(); cyc();
    #1 clr_n = 1'b1;
    setc(1, 1, 0, 0, 1, 4'd0);
    for (int i = 0; i < 4; i++) cyc();             // R2 hold then count
    // up wrap in both variants: R6
    setc(1, 0, 1, 1, 1, 4'd8); cyc();
    setc(1, 1, 0, 0, 1, 4'd0);
    for (int i = 0; i < 9; i++) cyc();
    // down wrap from 0: R6
    setc(0, 0, 0, 0, 0, 4'd5); cyc();              // R3 over load
    setc(1, 1, 0, 0, 0, 4'd0);
    for (int i = 0; i < 3; i++) cyc();
    // illegal decade values: R7
    for (int v = 10; v < 16; v++) begin
      setc(1, 0, 0, 0, 1, 4'(v)); cyc();           // R4 load over count
      setc(1, 1, 0, 0, 1, 4'd0); cyc();
      setc(1, 0, 1, 1, 1, 4'(v)); cyc();
      setc(1, 1, 0, 0, 0, 4'd0); cyc();
    end
    // enable gating R5 and carry gating R8/R9
    setc(1, 0, 1, 1, 1, 4'd9); cyc();
    setc(1, 1, 1, 0, 1, 4'd0); cyc();
    setc(1, 1, 0, 1, 1, 4'd0); cyc();
    oe_n = 1'b1;
    setc(1, 1, 0, 0, 1, 4'd0); cyc(); cyc();       // R10 count while released
    oe_n = 1'b0;
    // asynchronous clear mid-cycle: R1, R2
    #2 clr_n = 1'b0;
    #1 chk("R1", "async clr dec", cnt_d, 4'd0);
    chk("R1", "async clr bin", cnt_b, 4'd0);
    m_d = 0; m_b = 0; hold = 2;
    setc(1, 0, 0, 0, 1, 4'd7); cyc();
    clr_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();
    // random
    for (int i = 0; i < 4000; i++) begin
      setc(($urandom % 16) != 0, ($urandom % 8) != 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, $urandom % 2, 4'($urandom));
      oe_n = ($urandom % 4) == 0;
      if (($urandom % 200) == 0) begin
        clr_n = 1'b0; #1;
        chk("R1", "rand clr", cnt_d, 4'd0);
        m_d = 0; m_b = 0; hold = 2;
        cyc();
        clr_n = 1'b1;
      end else cyc();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule